// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block turns a handful of software-written registers into the raster timing of one display channel. A horizontal and a vertical counter sweep a frame whose active size, total size and sync windows come from the timing registers. From the counters it drives horizontal sync, vertical sync, a data-enable strobe and a single-cycle vertical-blank pulse. A 32-bit frame counter counts vertical blanks. Two frame base addresses are stored, and a page-flip request moves scanout between them at a frame boundary.

Software reaches the block through a plain 32-bit register port: a 4-bit word address, write data, a write strobe and combinational read data. The control word carries an active-low soft reset, an output enable, the flip request, a two-bit burst-step code that is only passed out to the fetch engine, and a read-only stall flag. The live scan position, the frame counter, an interrupt enable and a write-one-to-clear interrupt status can all be read back. After power-up the soft reset bit is low, so the scan stays parked at the origin until software lifts it.

Top module: `disp_timing_gen`

## Requirements
- R1: Address 1 holds the line total in bits 31:16 and active width in bits 15:0; address 2 holds the frame total (lines) and active height the same way. The horizontal count runs 0 to total-1 and wraps to 0, and the vertical count advances by one on each horizontal wrap and wraps after total-1.
- R2: Data-enable is high exactly when the output enable is set, the horizontal count is below the active width and the vertical count is below the active height.
- R3: Addresses 3 (horizontal) and 4 (vertical) hold the sync end in bits 31:16, a sync enable in bit 15 and the sync start in bits 14:0. With the enable set and the output enabled, the sync output is active while start <= count < end; with bit 15 clear it stays inactive. Default polarity is active high.
- R4: Address 5 reads the live horizontal count in bits 31:16 and the live vertical count in bits 15:0.
- R5: The vblank output pulses for one cycle when the horizontal count is 0 and the vertical count equals the active height. The frame counter at address 6 becomes one larger on the next cycle, and it keeps counting while the output enable is clear.
- R6: Control bit 0 is an active-low soft reset. While it is 0, both counters and the frame counter read 0 and the stall flag clears. Timing registers, frame addresses, the active buffer and the burst step keep their values.
- R7: Control bit 1 is the output enable. While it is 0, hsync, vsync and data-enable are inactive, but the scan position keeps moving.
- R8: Writing 1 to control bit 2 sets a pending flip, which reads back as 1 in bit 2. At the next vblank pulse, the active buffer toggles and the pending bit clears. A request written in the very cycle of a vblank pulse waits for the following pulse. The frame address output is the address-8 word when the active buffer is 0 and the address-9 word when it is 1.
- R9: Control bits 5:4 hold the burst-step code (0 = 32, 1 = 64, 2 = 128, 3 = 256 bytes). It is exported on burst_step and read back in place.
- R10: At address 7, bit 0 is the interrupt enable and bit 1 is the status. Status sets on every vblank pulse and clears when 1 is written to bit 1. irq equals enable AND status. If the clear and a vblank pulse fall in the same cycle, the set wins.
- R11: Control bit 8 (read-only) becomes 1 once the horizontal count has stayed unchanged for max(line total, 2) consecutive enabled cycles, and it stays 1 until a soft reset.
- R12: After the hardware reset, the control word reads 0. Position, frame count, irq, data-enable, both syncs, burst_step and fb_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active-pixel data enable |
| vblank | output | 1 | One-cycle pulse at the start of vertical blank |
| irq | output | 1 | Masked vertical-blank interrupt |
| fb_addr | output | FBW | Base address of the buffer being scanned |
| burst_step | output | 2 | Stored burst-step code for the fetch engine |

## Verification
The vblank event can land on the same clock edge as a register write that touches the state it updates. Two such collisions matter: a write-one-to-clear of the interrupt status, and a page-flip request. The bench counts cycles from the release of soft reset, so it knows the exact edge of each vblank pulse. It asserts the write strobe in that cycle. It then checks that the status survives the clear. It also checks that the flip stays pending with the old buffer selected, and that the flip takes effect only one frame later.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   localparam int REG_W = 32;

   // register word addresses
   localparam logic [3:0] RA_CTRL  = 4'd0;
   localparam logic [3:0] RA_HTIM  = 4'd1;
   localparam logic [3:0] RA_VTIM  = 4'd2;
   localparam logic [3:0] RA_HSYNC = 4'd3;
   localparam logic [3:0] RA_VSYNC = 4'd4;
   localparam logic [3:0] RA_POS   = 4'd5;
   localparam logic [3:0] RA_FCNT  = 4'd6;
   localparam logic [3:0] RA_IRQ   = 4'd7;
   localparam logic [3:0] RA_FB0   = 4'd8;
   localparam logic [3:0] RA_FBSEL = 4'd10;

   // control word bit positions
   localparam int CTL_SRSTN = 0;
   localparam int CTL_OEN   = 1;
   localparam int CTL_FLIP  = 2;
   localparam int CTL_STEP  = 4;
   localparam int CTL_STALL = 8;

   // interrupt word bit positions
   localparam int IRQ_EN = 0;
   localparam int IRQ_ST = 1;

   typedef struct packed {
      logic [15:0] total;
      logic [15:0] active;
   } span_t;

   typedef struct packed {
      logic [15:0] stop;
      logic        en;
      logic [14:0] start;
   } sync_t;

   function automatic logic in_window(input logic [15:0] cnt,
                                      input logic [14:0] first,
                                      input logic [15:0] last);
      return (cnt >= {1'b0, first}) && (cnt < last);
   endfunction

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
   import dtg_pkg::*;
#(
   parameter int CW  = 16,
   parameter int FCW = 32,
   parameter int FBW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      addr,
   input  logic [31:0]     wdata,
   input  logic            we,
   output logic [31:0]     rdata,
   input  logic [CW-1:0]   h_cnt,
   input  logic [CW-1:0]   v_cnt,
   input  logic [FCW-1:0]  fcnt,
   input  logic            stall,
   input  logic            vblank,
   output logic            srst_n,
   output logic            out_en,
   output logic [1:0]      step,
   output span_t           htim,
   output span_t           vtim,
   output sync_t           hsy,
   output sync_t           vsy,
   output logic [FBW-1:0]  fb_addr,
   output logic            irq
);

   logic srstn_q, oen_q, flip_pend, fb_sel, irq_en_q, irq_st_q;
   logic [1:0] step_q;
   span_t htim_q, vtim_q;
   sync_t hsy_q, vsy_q;

   logic wr_ctrl, wr_irq, clr_st;
   assign wr_ctrl = we && (addr == RA_CTRL);
   assign wr_irq  = we && (addr == RA_IRQ);
   assign clr_st  = wr_irq && wdata[IRQ_ST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srstn_q   <= 1'b0;
         oen_q     <= 1'b0;
         step_q    <= '0;
         flip_pend <= 1'b0;
         fb_sel    <= 1'b0;
         irq_en_q  <= 1'b0;
         irq_st_q  <= 1'b0;
         htim_q    <= '0;
         vtim_q    <= '0;
         hsy_q     <= '0;
         vsy_q     <= '0;
      end else begin
         if (vblank && flip_pend) begin
            fb_sel    <= ~fb_sel;
            flip_pend <= 1'b0;
         end
         if (wr_ctrl) begin
            srstn_q <= wdata[CTL_SRSTN];
            oen_q   <= wdata[CTL_OEN];
            step_q  <= wdata[CTL_STEP +: 2];
            if (wdata[CTL_FLIP]) flip_pend <= 1'b1;
         end
         if (wr_irq) irq_en_q <= wdata[IRQ_EN];
         irq_st_q <= (irq_st_q && !clr_st) || vblank;
         if (we && addr == RA_HTIM)  htim_q <= wdata;
         if (we && addr == RA_VTIM)  vtim_q <= wdata;
         if (we && addr == RA_HSYNC) hsy_q  <= wdata;
         if (we && addr == RA_VSYNC) vsy_q  <= wdata;
      end
   end

   // two frame base registers, one generated slot each
   for (genvar b = 0; b < 2; b++) begin : g_fb
      logic [FBW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= '0;
         else if (we && addr == RA_FB0 + 4'(b)) q <= wdata[FBW-1:0];
      end
   end

   assign fb_addr = fb_sel ? g_fb[1].q : g_fb[0].q;
   assign srst_n  = srstn_q;
   assign out_en  = oen_q;
   assign step    = step_q;
   assign htim    = htim_q;
   assign vtim    = vtim_q;
   assign hsy     = hsy_q;
   assign vsy     = vsy_q;
   assign irq     = irq_en_q && irq_st_q;

   always_comb begin
      rdata = '0;
      case (addr)
         RA_CTRL: begin
            rdata[CTL_SRSTN]     = srstn_q;
            rdata[CTL_OEN]       = oen_q;
            rdata[CTL_FLIP]      = flip_pend;
            rdata[CTL_STEP +: 2] = step_q;
            rdata[CTL_STALL]     = stall;
         end
         RA_HTIM:  rdata = htim_q;
         RA_VTIM:  rdata = vtim_q;
         RA_HSYNC: rdata = hsy_q;
         RA_VSYNC: rdata = vsy_q;
         RA_POS:   rdata = {16'(h_cnt), 16'(v_cnt)};
         RA_FCNT:  rdata = REG_W'(fcnt);
         RA_IRQ: begin
            rdata[IRQ_EN] = irq_en_q;
            rdata[IRQ_ST] = irq_st_q;
         end
         RA_FB0:     rdata = REG_W'(g_fb[0].q);
         RA_FB0 + 4'd1: rdata = REG_W'(g_fb[1].q);
         RA_FBSEL:   rdata[0] = fb_sel;
         default:    rdata = '0;
      endcase
   end

   // R8: the active buffer moves only on a vblank pulse
   p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !vblank |=> $stable(fb_sel));

endmodule

// File: rtl/dtg_scan.sv
module dtg_scan #(
   parameter int CW  = 16,
   parameter int FCW = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           srst_n,
   input  logic           out_en,
   input  logic [CW-1:0]  htot,
   input  logic [CW-1:0]  vtot,
   input  logic [CW-1:0]  vact,
   output logic [CW-1:0]  h_cnt,
   output logic [CW-1:0]  v_cnt,
   output logic           vblank,
   output logic [FCW-1:0] fcnt,
   output logic           stall
);

   localparam logic [CW-1:0]  C_ONE = CW'(1);
   localparam logic [CW:0]    R_ONE = (CW+1)'(1);
   localparam logic [CW:0]    R_TWO = (CW+1)'(2);
   localparam logic [FCW-1:0] F_ONE = FCW'(1);

   logic [CW-1:0]  h_q, v_q, h_last;
   logic [FCW-1:0] f_q;
   logic [CW:0]    run_q, thr;
   logic           stall_q, h_end, v_end;

   assign h_end  = h_q >= (htot - C_ONE);
   assign v_end  = v_q >= (vtot - C_ONE);
   assign vblank = srst_n && (h_q == '0) && (v_q == vact);
   assign thr    = (htot < CW'(2)) ? R_TWO : {1'b0, htot};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q <= '0; v_q <= '0; h_last <= '0; f_q <= '0;
         run_q <= '0; stall_q <= 1'b0;
      end else if (!srst_n) begin
         h_q <= '0; v_q <= '0; h_last <= '0; f_q <= '0;
         run_q <= '0; stall_q <= 1'b0;
      end else begin
         h_q    <= h_end ? '0 : h_q + C_ONE;
         if (h_end) v_q <= v_end ? '0 : v_q + C_ONE;
         if (vblank) f_q <= f_q + F_ONE;
         h_last <= h_q;
         if (out_en && (h_q == h_last)) begin
            if (run_q != '1) run_q <= run_q + R_ONE;
         end else begin
            run_q <= '0;
         end
         if (run_q >= thr) stall_q <= 1'b1;
      end
   end

   assign h_cnt = h_q;
   assign v_cnt = v_q;
   assign fcnt  = f_q;
   assign stall = stall_q;

   // R5: one frame counted per vblank pulse
   p_fcnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vblank |=> (f_q == $past(f_q) + F_ONE));

   // R6: soft reset parks the scan and clears the stall flag
   p_soft_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !srst_n |=> (h_q == '0 && v_q == '0 && f_q == '0 && !stall_q));

endmodule

// File: rtl/dtg_out.sv
module dtg_out
   import dtg_pkg::*;
#(
   parameter int         CW       = 16,
   parameter logic [1:0] SYNC_POL = 2'b11
) (
   input  logic           out_en,
   input  logic [CW-1:0]  h_cnt,
   input  logic [CW-1:0]  v_cnt,
   input  logic [CW-1:0]  hact,
   input  logic [CW-1:0]  vact,
   input  sync_t          hsy,
   input  sync_t          vsy,
   output logic           de,
   output logic           hs,
   output logic           vs
);

   logic [CW-1:0] cnt [2];
   sync_t         win [2];
   logic [1:0]    sy;

   assign cnt[0] = h_cnt;
   assign cnt[1] = v_cnt;
   assign win[0] = hsy;
   assign win[1] = vsy;

   // one sync decoder per axis; polarity chosen per axis
   for (genvar a = 0; a < 2; a++) begin : g_axis
      logic raw;
      assign raw = out_en && win[a].en && in_window(16'(cnt[a]), win[a].start, win[a].stop);
      if (SYNC_POL[a]) begin : g_high
         assign sy[a] = raw;
      end else begin : g_low
         assign sy[a] = ~raw;
      end
   end

   assign de = out_en && (h_cnt < hact) && (v_cnt < vact);
   assign hs = sy[0];
   assign vs = sy[1];

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
   import dtg_pkg::*;
#(
   parameter int         CW       = 16,
   parameter int         FCW      = 32,
   parameter int         FBW      = 32,
   parameter logic [1:0] SYNC_POL = 2'b11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   input  logic            reg_we,
   output logic [31:0]     reg_rdata,
   output logic            hsync,
   output logic            vsync,
   output logic            de,
   output logic            vblank,
   output logic            irq,
   output logic [FBW-1:0]  fb_addr,
   output logic [1:0]      burst_step
);

   if (CW < 4 || CW > 16) begin : g_bad_cw
      $error("CW must lie in 4..16");
   end
   if (FCW < 1 || FCW > REG_W) begin : g_bad_fcw
      $error("FCW must lie in 1..32");
   end
   if (FBW < 1 || FBW > REG_W) begin : g_bad_fbw
      $error("FBW must lie in 1..32");
   end

   logic           srst_n, out_en, stall, vbl;
   logic [CW-1:0]  h_cnt, v_cnt;
   logic [FCW-1:0] fcnt;
   span_t          htim, vtim;
   sync_t          hsy, vsy;

   dtg_regs #(.CW(CW), .FCW(FCW), .FBW(FBW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .we      (reg_we),
      .rdata   (reg_rdata),
      .h_cnt   (h_cnt),
      .v_cnt   (v_cnt),
      .fcnt    (fcnt),
      .stall   (stall),
      .vblank  (vbl),
      .srst_n  (srst_n),
      .out_en  (out_en),
      .step    (burst_step),
      .htim    (htim),
      .vtim    (vtim),
      .hsy     (hsy),
      .vsy     (vsy),
      .fb_addr (fb_addr),
      .irq     (irq)
   );

   dtg_scan #(.CW(CW), .FCW(FCW)) u_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst_n (srst_n),
      .out_en (out_en),
      .htot   (htim.total[CW-1:0]),
      .vtot   (vtim.total[CW-1:0]),
      .vact   (vtim.active[CW-1:0]),
      .h_cnt  (h_cnt),
      .v_cnt  (v_cnt),
      .vblank (vbl),
      .fcnt   (fcnt),
      .stall  (stall)
   );

   dtg_out #(.CW(CW), .SYNC_POL(SYNC_POL)) u_out (
      .out_en (out_en),
      .h_cnt  (h_cnt),
      .v_cnt  (v_cnt),
      .hact   (htim.active[CW-1:0]),
      .vact   (vtim.active[CW-1:0]),
      .hsy    (hsy),
      .vsy    (vsy),
      .de     (de),
      .hs     (hsync),
      .vs     (vsync)
   );

   assign vblank = vbl;

   // R7: with the output disabled every video strobe sits at its idle level
   p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> (!de && (hsync == !SYNC_POL[0]) && (vsync == !SYNC_POL[1])));

endmodule

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic        hsync, vsync, de, vblank, irq;
   logic [31:0] fb_addr;
   logic [1:0]  burst_step;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int base = 0;
   bit done = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   disp_timing_gen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_we     (reg_we),
      .reg_rdata  (reg_rdata),
      .hsync      (hsync),
      .vsync      (vsync),
      .de         (de),
      .vblank     (vblank),
      .irq        (irq),
      .fb_addr    (fb_addr),
      .burst_step (burst_step)
   );

   // {t, h, v, de, hs, vs, vblank}: line total 10, width 6, hsync 7..8,
   // frame total 6, height 4, vsync on line 4
   localparam int NV = 13;
   localparam logic [19:0] VEC [NV] = '{
      {8'd0,  4'd0, 4'd0, 4'b1000},
      {8'd5,  4'd5, 4'd0, 4'b1000},
      {8'd6,  4'd6, 4'd0, 4'b0000},
      {8'd7,  4'd7, 4'd0, 4'b0100},
      {8'd8,  4'd8, 4'd0, 4'b0100},
      {8'd9,  4'd9, 4'd0, 4'b0000},
      {8'd10, 4'd0, 4'd1, 4'b1000},
      {8'd39, 4'd9, 4'd3, 4'b0000},
      {8'd40, 4'd0, 4'd4, 4'b0011},
      {8'd41, 4'd1, 4'd4, 4'b0010},
      {8'd47, 4'd7, 4'd4, 4'b0110},
      {8'd50, 4'd0, 4'd5, 4'b0000},
      {8'd60, 4'd0, 4'd0, 4'b1000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_t(input int n);
      while ((cyc - base) < n) @(negedge clk);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, f0, p0;
      int bad;
      repeat (3) @(negedge clk);
      // R12 reset state
      rd(4'd0, d);  chk("R12 ctrl", d, 32'h0);
      rd(4'd5, d);  chk("R12 pos", d, 32'h0);
      rd(4'd6, d);  chk("R12 fcnt", d, 32'h0);
      chk("R12 strobes", {27'd0, de, hsync, vsync, irq, vblank}, 32'h0);
      chk("R12 fb/step", {fb_addr[29:0], burst_step}, 32'h0);
      rst_n = 1'b1;
      // program while parked
      wr(4'd1, 32'h000A_0006);
      wr(4'd2, 32'h0006_0004);
      wr(4'd3, 32'h0009_8007);
      wr(4'd4, 32'h0005_8004);
      wr(4'd8, 32'h0000_1000);
      wr(4'd9, 32'h0000_2000);
      wr(4'd7, 32'h1);
      wr(4'd0, 32'h3);
      base = cyc;
      // R1 R2 R3 R4 R5: vector walk
      for (int i = 0; i < NV; i++) begin
         wait_t(int'(VEC[i][19:12]));
         rd(4'd5, d);
         chk("R1/R4 position", d, {12'd0, VEC[i][11:8], 12'd0, VEC[i][7:4]});
         chk("R2/R3/R5 strobes", {28'd0, de, hsync, vsync, vblank}, {28'd0, VEC[i][3:0]});
      end
      rd(4'd6, d);  chk("R5 fcnt first frame", d, 32'd1);
      chk("R10 irq raised", {31'd0, irq}, 32'd1);
      wr(4'd7, 32'h3);
      chk("R10 w1c clears", {31'd0, irq}, 32'd0);
      // R10 clear in the vblank cycle: set wins
      wait_t(100);
      reg_addr = 4'd7; reg_wdata = 32'h3; reg_we = 1'b1;
      @(negedge clk); reg_we = 1'b0;
      chk("R10 set beats clear", {31'd0, irq}, 32'd1);
      wr(4'd7, 32'h3);
      // R8 flip written in the vblank cycle is deferred
      wait_t(160);
      reg_addr = 4'd0; reg_wdata = 32'h7; reg_we = 1'b1;
      @(negedge clk); reg_we = 1'b0;
      chk("R8 deferred buffer", fb_addr, 32'h1000);
      rd(4'd0, d);  chk("R8 pending bit", {31'd0, d[2]}, 32'd1);
      wait_t(221);
      chk("R8 flipped", fb_addr, 32'h2000);
      rd(4'd0, d);  chk("R8 pending cleared", {31'd0, d[2]}, 32'd0);
      wr(4'd0, 32'h7);
      wait_t(281);
      chk("R8 flipped back", fb_addr, 32'h1000);
      rd(4'd6, d);  chk("R5 fcnt five frames", d, 32'd5);
      // R7 output disabled, counters and R5 frame count still run
      wr(4'd0, 32'h1);
      rd(4'd6, f0); rd(4'd5, p0);
      bad = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (de || hsync || vsync) bad++;
         if (i == 1) begin
            rd(4'd5, d);
            chk("R7 position moves", {31'd0, d != p0}, 32'd1);
         end
      end
      chk("R7 strobes idle", bad, 0);
      rd(4'd6, d);  chk("R5 counts while disabled", d, f0 + 32'd1);
      // R3 sync enable clear
      wr(4'd0, 32'h3);
      wr(4'd3, 32'h0009_0007);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (hsync) bad++;
      end
      chk("R3 hsync disabled", bad, 0);
      // R9 burst step
      wr(4'd0, 32'h23);
      chk("R9 burst port", {30'd0, burst_step}, 32'd2);
      rd(4'd0, d);  chk("R9 burst readback", {30'd0, d[5:4]}, 32'd2);
      // R6 soft reset
      wr(4'd0, 32'h20);
      @(negedge clk);
      rd(4'd5, d);  chk("R6 position held", d, 32'h0);
      rd(4'd6, d);  chk("R6 fcnt cleared", d, 32'h0);
      rd(4'd1, d);  chk("R6 timing kept", d, 32'h000A_0006);
      chk("R6 buffer kept", fb_addr, 32'h1000);
      chk("R6 step kept", {30'd0, burst_step}, 32'd2);
      // R11 stall: line total 1 leaves the horizontal count frozen
      wr(4'd1, 32'h0001_0001);
      wr(4'd0, 32'h3);
      repeat (6) @(negedge clk);
      rd(4'd0, d);  chk("R11 stall set", {31'd0, d[8]}, 32'd1);
      wr(4'd0, 32'h2);
      @(negedge clk);
      rd(4'd0, d);  chk("R11 stall cleared by soft reset", {31'd0, d[8]}, 32'd0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule